// File: doc/BRIEF.md
# Address Translation Cache with Selective Flush

This block keeps recently translated pages for a paged memory unit. It has a user bank and a supervisor bank, and each bank is direct-mapped. A lookup presents a logical address together with a supervisor flag, a data/instruction flag and a write flag. One cycle later the block reports a hit, a miss or a fault, and on a hit it also gives the physical address. On a miss the requester runs a table walk outside this block. It then returns the result through the refill port. The refill port also carries a transparent-window outcome, computed elsewhere, that can take precedence over the descriptor.

A 16-bit control register enables translation and selects between 4 KB and 8 KB pages. Any write to it empties the whole cache. Software-level maintenance has two commands, flush one page and flush everything, and a qualifier on each decides whether global entries are also removed. A refill can be marked as a test. A test refill loads the entry as usual and also latches a status word that describes the result of the translation.

Top module: `atc_xlate_cache`

## Requirements
- R1: The supervisor flag selects the bank. Logical address bits [15:12] select the entry, and bits [31:16] form the tag. A lookup result (rsp_valid, rsp_hit, rsp_fault, rsp_paddr) appears in the cycle after lk_valid. A lookup is a miss when the entry is empty or its tag differs. Hit and fault are never both set.
- R2: On a descriptor refill the stored offset is the descriptor frame minus the logical frame. Frames are taken with bits [11:0] cleared for 4 KB pages and bits [12:0] cleared for 8 KB pages. A hit returns the logical address plus this offset.
- R3: A write that hits an entry with write-protect set faults. A read of the same entry hits.
- R4: A write that hits an entry whose modified bit is clear is reported as a miss without a fault.
- R5: A descriptor refill stores a faulting entry in two cases: descriptor bit 0 (resident) is clear, or a user refill has descriptor bit 7 (supervisor-only) set. A lookup of that page then faults.
- R6: While control bit 15 is clear, a refill that is not transparent stores an identity mapping. That mapping is valid for data and instruction, global, modified and writable.
- R7: A transparent refill (rf_tt_hit) stores a zero offset and is valid for the requesting access type. It is valid for the other access type only when rf_tt_both is set. Its write-protect comes from rf_tt_wp, and it is global and modified. A lookup of the other access type faults when rf_tt_both is clear.
- R8: A single-page flush clears entry fl_idx in the bank chosen by fl_super. In 8 KB mode it also clears entry fl_idx XOR 1. Other entries and the other bank keep their contents.
- R9: Both flush commands spare an entry whose global bit (descriptor bit 10) is set, unless fl_global is set.
- R10: Control bit 15 enables translation and bit 14 selects 8 KB pages. A control write empties every entry, global ones included. A lookup in the next cycle misses.
- R11: A test refill updates tst_status one cycle later. A faulting result gives only bit 11. A transparent result gives bits 1 and 0. A normal result gives descriptor bits [31:12], 10, 7, 6:5, 4 and 2, with bit 0 set.
- R12: Reset empties both banks and clears the control register and tst_status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write the control register |
| ctl_wdata | input | 16 | Control value (bit 15 enable, bit 14 8 KB pages) |
| ctl_value | output | 16 | Current control register |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup logical address |
| lk_super | input | 1 | Lookup in supervisor mode |
| lk_data | input | 1 | Lookup is a data access (else instruction) |
| lk_write | input | 1 | Lookup is a write |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_fault | output | 1 | Lookup faulted (invalid or write-protected) |
| rsp_paddr | output | 32 | Physical address on hit |
| rf_valid | input | 1 | Refill from walk result |
| rf_addr | input | 32 | Refill logical address |
| rf_super | input | 1 | Refill supervisor mode (bank) |
| rf_data | input | 1 | Refill requesting access is data |
| rf_desc | input | 32 | Page descriptor from walk |
| rf_tt_hit | input | 1 | Transparent window matched |
| rf_tt_wp | input | 1 | Matched window is write-protected |
| rf_tt_both | input | 1 | Window matches both access types |
| rf_test | input | 1 | Latch test status from this refill |
| tst_status | output | 32 | Test status word |
| fl_one | input | 1 | Flush one page index |
| fl_all | input | 1 | Flush all entries |
| fl_idx | input | 4 | Page index (logical address bits [15:12]) to flush |
| fl_super | input | 1 | Bank for single-page flush |
| fl_global | input | 1 | Flush global entries too |

## Verification
Every result is due one clock after its stimulus. A lookup result registers at the edge that samples lk_valid. A refill, flush or control write changes the stored entries at its edge, so a lookup presented in the following cycle already sees the change. A test refill updates tst_status at its own edge. The bench drives every stimulus on the falling edge, waits for the next rising edge, and samples one nanosecond later. No check sits in a cycle where the value is still moving. When two operations must be ordered, they go in separate cycles, one after the other.

// File: rtl/atc_pkg.sv
package atc_pkg;

    localparam int VA_W     = 32;
    localparam int PG_SHIFT = 12;

    // descriptor bit positions
    localparam int D_RES = 0;
    localparam int D_WP  = 2;
    localparam int D_MOD = 4;
    localparam int D_CM0 = 5;
    localparam int D_CM1 = 6;
    localparam int D_SUP = 7;
    localparam int D_GLB = 10;

    // status bit positions
    localparam int S_RES = 0;
    localparam int S_TT  = 1;
    localparam int S_INV = 11;

    // control register bit positions
    localparam int C_EN  = 15;
    localparam int C_BIG = 14;

    typedef struct packed {
        logic [VA_W-1:0] ofs;
        logic            glob;
        logic            tt;
        logic            modf;
        logic            wp;
        logic            vd;
        logic            vi;
    } atc_attr_t;

    function automatic logic [VA_W-1:0] frame_mask(input logic big);
        if (big)
            return ~((VA_W'(1) << (PG_SHIFT + 1)) - VA_W'(1));
        return ~((VA_W'(1) << PG_SHIFT) - VA_W'(1));
    endfunction

    function automatic logic [VA_W-1:0] status_keep();
        logic [VA_W-1:0] m;
        m = frame_mask(1'b0);
        m[D_GLB] = 1'b1;
        m[D_SUP] = 1'b1;
        m[D_CM1] = 1'b1;
        m[D_CM0] = 1'b1;
        m[D_MOD] = 1'b1;
        m[D_WP]  = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/atc_refill_fmt.sv
module atc_refill_fmt
    import atc_pkg::*;
(
    input  logic [VA_W-1:0] addr,
    input  logic            super_m,
    input  logic            data_m,
    input  logic            xlate_en,
    input  logic            big_page,
    input  logic            tt_hit,
    input  logic            tt_wp,
    input  logic            tt_both,
    input  logic [VA_W-1:0] desc,
    output atc_attr_t       attr,
    output logic [VA_W-1:0] status
);

    logic [VA_W-1:0] fmask;
    logic            desc_ok;

    assign fmask   = frame_mask(big_page);
    assign desc_ok = desc[D_RES] && !(!super_m && desc[D_SUP]);

    always_comb begin
        attr   = '0;
        status = '0;
        if (tt_hit) begin
            attr.tt   = 1'b1;
            attr.vd   = data_m || tt_both;
            attr.vi   = !data_m || tt_both;
            attr.glob = 1'b1;
            attr.modf = 1'b1;
            attr.wp   = tt_wp;
            status[S_TT]  = 1'b1;
            status[S_RES] = 1'b1;
        end else if (!xlate_en) begin
            attr.vd   = 1'b1;
            attr.vi   = 1'b1;
            attr.glob = 1'b1;
            attr.modf = 1'b1;
            status[S_RES] = 1'b1;
        end else if (desc_ok) begin
            attr.vd   = 1'b1;
            attr.vi   = 1'b1;
            attr.ofs  = (desc & fmask) - (addr & fmask);
            attr.glob = desc[D_GLB];
            attr.modf = desc[D_MOD];
            attr.wp   = desc[D_WP];
            status        = desc & status_keep();
            status[S_RES] = 1'b1;
        end else begin
            status[S_INV] = 1'b1;
        end
    end

endmodule

// File: rtl/atc_bank.sv
module atc_bank
    import atc_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             clr_glob,
    input  logic             one_en,
    input  logic             one_pair,
    input  logic [IDX_W-1:0] one_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  atc_attr_t        wr_attr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_used,
    output logic [TAG_W-1:0] rd_tag,
    output atc_attr_t        rd_attr
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] used_q;
    logic [DEPTH-1:0] sel_v;
    logic [DEPTH-1:0] clr_v;
    logic [TAG_W-1:0] tag_q  [DEPTH];
    atc_attr_t        attr_q [DEPTH];
    logic [IDX_W-1:0] pair_idx;

    assign pair_idx = one_idx ^ IDX_W'(1);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            sel_v[i] = clr_all ||
                       (one_en && ((one_idx == IDX_W'(i)) ||
                                   (one_pair && (pair_idx == IDX_W'(i)))));
            clr_v[i] = sel_v[i] && (clr_glob || !attr_q[i].glob);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (clr_v[i])
                    used_q[i] <= 1'b0;
                else if (wr_en && (wr_idx == IDX_W'(i)))
                    used_q[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            attr_q[wr_idx] <= wr_attr;
        end
    end

    assign rd_used = used_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
    assign rd_attr = attr_q[rd_idx];

endmodule

// File: rtl/atc_hit_eval.sv
module atc_hit_eval
    import atc_pkg::*;
#(
    parameter int TAG_W = 16
) (
    input  logic             used,
    input  logic [TAG_W-1:0] tag,
    input  atc_attr_t        attr,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [VA_W-1:0]  lk_addr,
    input  logic             lk_data,
    input  logic             lk_write,
    output logic             hit,
    output logic             fault,
    output logic [VA_W-1:0]  paddr
);

    logic match;
    logic type_ok;

    assign match   = used && (tag == lk_tag);
    assign type_ok = lk_data ? attr.vd : attr.vi;
    assign fault   = match && (!type_ok || (lk_write && attr.wp));
    assign hit     = match && !fault && !(lk_write && !attr.modf);
    assign paddr   = attr.tt ? lk_addr : (lk_addr + attr.ofs);

endmodule

// File: rtl/atc_xlate_cache.sv
module atc_xlate_cache
    import atc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [15:0]      ctl_wdata,
    output logic [15:0]      ctl_value,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_addr,
    input  logic             lk_super,
    input  logic             lk_data,
    input  logic             lk_write,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic [VA_W-1:0]  rsp_paddr,
    input  logic             rf_valid,
    input  logic [VA_W-1:0]  rf_addr,
    input  logic             rf_super,
    input  logic             rf_data,
    input  logic [VA_W-1:0]  rf_desc,
    input  logic             rf_tt_hit,
    input  logic             rf_tt_wp,
    input  logic             rf_tt_both,
    input  logic             rf_test,
    output logic [VA_W-1:0]  tst_status,
    input  logic             fl_one,
    input  logic             fl_all,
    input  logic [IDX_W-1:0] fl_idx,
    input  logic             fl_super,
    input  logic             fl_global
);

    localparam int TAG_W  = VA_W - PG_SHIFT - IDX_W;
    localparam int NBANKS = 2;

    logic [15:0]      ctl_q;
    logic             xlate_en;
    logic             big_page;
    atc_attr_t        rf_attr;
    logic [VA_W-1:0]  rf_status;
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] rf_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [TAG_W-1:0] rf_tag;

    logic             b_used [NBANKS];
    logic [TAG_W-1:0] b_tag  [NBANKS];
    atc_attr_t        b_attr [NBANKS];

    logic             hit_c;
    logic             fault_c;
    logic [VA_W-1:0]  paddr_c;

    assign xlate_en  = ctl_q[C_EN];
    assign big_page  = ctl_q[C_BIG];
    assign ctl_value = ctl_q;

    assign lk_idx = lk_addr[PG_SHIFT +: IDX_W];
    assign lk_tag = lk_addr[VA_W-1 -: TAG_W];
    assign rf_idx = rf_addr[PG_SHIFT +: IDX_W];
    assign rf_tag = rf_addr[VA_W-1 -: TAG_W];

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (ctl_wr)
            ctl_q <= ctl_wdata;
    end

    atc_refill_fmt u_fmt (
        .addr     (rf_addr),
        .super_m  (rf_super),
        .data_m   (rf_data),
        .xlate_en (xlate_en),
        .big_page (big_page),
        .tt_hit   (rf_tt_hit),
        .tt_wp    (rf_tt_wp),
        .tt_both  (rf_tt_both),
        .desc     (rf_desc),
        .attr     (rf_attr),
        .status   (rf_status)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        atc_bank #(
            .IDX_W (IDX_W),
            .TAG_W (TAG_W)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .clr_all  (fl_all || ctl_wr),
            .clr_glob (fl_global || ctl_wr),
            .one_en   (fl_one && (fl_super == b[0])),
            .one_pair (big_page),
            .one_idx  (fl_idx),
            .wr_en    (rf_valid && (rf_super == b[0])),
            .wr_idx   (rf_idx),
            .wr_tag   (rf_tag),
            .wr_attr  (rf_attr),
            .rd_idx   (lk_idx),
            .rd_used  (b_used[b]),
            .rd_tag   (b_tag[b]),
            .rd_attr  (b_attr[b])
        );
    end

    atc_hit_eval #(
        .TAG_W (TAG_W)
    ) u_eval (
        .used     (b_used[lk_super]),
        .tag      (b_tag[lk_super]),
        .attr     (b_attr[lk_super]),
        .lk_tag   (lk_tag),
        .lk_addr  (lk_addr),
        .lk_data  (lk_data),
        .lk_write (lk_write),
        .hit      (hit_c),
        .fault    (fault_c),
        .paddr    (paddr_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_paddr  <= '0;
            tst_status <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && hit_c;
            rsp_fault <= lk_valid && fault_c;
            rsp_paddr <= paddr_c;
            if (rf_valid && rf_test)
                tst_status <= rf_status;
        end
    end

endmodule

// File: rtl/atc_xlate_cache_chk.sv
module atc_xlate_cache_chk (
    input logic        clk,
    input logic        rst,
    input logic        lk_valid,
    input logic [11:0] lk_low,
    input logic        ctl_wr,
    input logic [15:0] ctl_value,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_fault,
    input logic [11:0] rsp_low,
    input logic        st_inv,
    input logic        st_res
);

    AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit && rsp_fault)); // R1

    AST_RSP_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid); // R1

    AST_RSP_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !(rsp_valid || rsp_hit || rsp_fault)); // R1

    AST_PAGE_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (!rsp_hit || rsp_low == $past(lk_low))); // R2

    AST_CTL_FLUSHES: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && $past(ctl_wr)) |=> !rsp_hit); // R10

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_inv, st_res})); // R11

    AST_CTL_RESET: assert property (@(posedge clk)
        $past(rst) |-> ctl_value == 16'h0000); // R12

endmodule

bind atc_xlate_cache atc_xlate_cache_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_low    (lk_addr[11:0]),
    .ctl_wr    (ctl_wr),
    .ctl_value (ctl_value),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_fault (rsp_fault),
    .rsp_low   (rsp_paddr[11:0]),
    .st_inv    (tst_status[11]),
    .st_res    (tst_status[0])
);

// File: tb/atc_xlate_cache_test.sv
`timescale 1ns/1ps
module atc_xlate_cache_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_value;
    logic        lk_valid = 0, lk_super = 0, lk_data = 0, lk_write = 0;
    logic [31:0] lk_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [31:0] rsp_paddr;
    logic        rf_valid = 0, rf_super = 0, rf_data = 0;
    logic        rf_tt_hit = 0, rf_tt_wp = 0, rf_tt_both = 0, rf_test = 0;
    logic [31:0] rf_addr = '0, rf_desc = '0;
    logic [31:0] tst_status;
    logic        fl_one = 0, fl_all = 0, fl_super = 0, fl_global = 0;
    logic [3:0]  fl_idx = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    atc_xlate_cache uut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_value(ctl_value), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_super(lk_super), .lk_data(lk_data), .lk_write(lk_write),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rf_valid(rf_valid), .rf_addr(rf_addr),
        .rf_super(rf_super), .rf_data(rf_data), .rf_desc(rf_desc),
        .rf_tt_hit(rf_tt_hit), .rf_tt_wp(rf_tt_wp), .rf_tt_both(rf_tt_both),
        .rf_test(rf_test), .tst_status(tst_status), .fl_one(fl_one),
        .fl_all(fl_all), .fl_idx(fl_idx), .fl_super(fl_super),
        .fl_global(fl_global)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic lookup(input string req, input logic [31:0] a, input logic s,
                          input logic d, input logic w, input logic eh,
                          input logic ef, input logic [31:0] ep);
        @(negedge clk);
        lk_valid = 1; lk_addr = a; lk_super = s; lk_data = d; lk_write = w;
        @(posedge clk); #1;
        lk_valid = 0;
        chk(req, {29'b0, rsp_valid, rsp_hit, rsp_fault}, {29'b0, 1'b1, eh, ef});
        if (eh) chk(req, rsp_paddr, ep);
    endtask

    task automatic refill(input logic [31:0] a, input logic s, input logic d,
                          input logic [31:0] desc, input logic tt, input logic twp,
                          input logic tboth, input logic tst);
        @(negedge clk);
        rf_valid = 1; rf_addr = a; rf_super = s; rf_data = d; rf_desc = desc;
        rf_tt_hit = tt; rf_tt_wp = twp; rf_tt_both = tboth; rf_test = tst;
        @(posedge clk); #1;
        rf_valid = 0; rf_test = 0; rf_tt_hit = 0;
    endtask

    task automatic flush_one(input logic [31:0] a, input logic s, input logic g);
        @(negedge clk);
        fl_one = 1; fl_idx = a[15:12]; fl_super = s; fl_global = g;
        @(posedge clk); #1;
        fl_one = 0; fl_global = 0;
    endtask

    task automatic flush_all(input logic g);
        @(negedge clk);
        fl_all = 1; fl_global = g;
        @(posedge clk); #1;
        fl_all = 0; fl_global = 0;
    endtask

    task automatic ctl_write(input logic [15:0] v);
        @(negedge clk);
        ctl_wr = 1; ctl_wdata = v;
        @(posedge clk); #1;
        ctl_wr = 0;
    endtask

    task automatic t_reset;
        chk("R12 ctl", {16'b0, ctl_value}, 32'h0);
        chk("R12 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk("R12 status", tst_status, 32'h0);
        lookup("R12 empty", 32'h4000_5678, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_identity;
        refill(32'h0000_1234, 0, 1, 32'h0, 0, 0, 0, 0);
        lookup("R6 data", 32'h0000_1234, 0, 1, 0, 1, 0, 32'h0000_1234);
        lookup("R6 inst", 32'h0000_1234, 0, 0, 0, 1, 0, 32'h0000_1234);
        lookup("R6 write", 32'h0000_1234, 0, 1, 1, 1, 0, 32'h0000_1234);
    endtask

    task automatic t_enable;
        ctl_write(16'h8000);
        chk("R10 ctl", {16'b0, ctl_value}, 32'h0000_8000);
        lookup("R10 flushed", 32'h0000_1234, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_normal;
        refill(32'h4000_5678, 0, 1, 32'h0012_3011, 0, 0, 0, 0);
        lookup("R2 paddr", 32'h4000_5678, 0, 1, 0, 1, 0, 32'h0012_3678);
        lookup("R1 other bank", 32'h4000_5678, 1, 1, 0, 0, 0, 0);
        lookup("R1 tag", 32'h4100_5678, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_protect;
        refill(32'h2000_7abc, 0, 1, 32'h0030_0015, 0, 0, 0, 0);
        lookup("R3 read", 32'h2000_7abc, 0, 1, 0, 1, 0, 32'h0030_0abc);
        lookup("R3 write", 32'h2000_7abc, 0, 1, 1, 0, 1, 0);
        refill(32'h3000_9010, 0, 1, 32'h0050_0001, 0, 0, 0, 0);
        lookup("R4 read", 32'h3000_9010, 0, 1, 0, 1, 0, 32'h0050_0010);
        lookup("R4 write", 32'h3000_9010, 0, 1, 1, 0, 0, 0);
    endtask

    task automatic t_invalid;
        refill(32'h5000_A000, 0, 1, 32'h0060_0081, 0, 0, 0, 0);
        lookup("R5 user super-only", 32'h5000_A000, 0, 1, 0, 0, 1, 0);
        refill(32'h5000_B000, 0, 1, 32'h0000_0000, 0, 0, 0, 0);
        lookup("R5 not resident", 32'h5000_B000, 0, 1, 0, 0, 1, 0);
        refill(32'h5000_A000, 1, 1, 32'h0060_0081, 0, 0, 0, 0);
        lookup("R5 super ok", 32'h5000_A004, 1, 1, 0, 1, 0, 32'h0060_0004);
    endtask

    task automatic t_test_status;
        refill(32'h6000_C000, 1, 1, 32'h0077_74FD, 0, 0, 0, 1);
        chk("R11 normal", tst_status, 32'h0077_74F5);
        refill(32'h6000_D000, 0, 1, 32'h0000_0000, 0, 0, 0, 1);
        chk("R11 invalid", tst_status, 32'h0000_0800);
        refill(32'h6000_E000, 0, 1, 32'h0000_0000, 1, 0, 0, 1);
        chk("R11 transparent", tst_status, 32'h0000_0003);
    endtask

    task automatic t_transparent;
        refill(32'h7000_D123, 0, 1, 32'h0012_3011, 1, 1, 0, 0);
        lookup("R7 data", 32'h7000_D123, 0, 1, 0, 1, 0, 32'h7000_D123);
        lookup("R7 inst", 32'h7000_D123, 0, 0, 0, 0, 1, 0);
        lookup("R7 wp", 32'h7000_D123, 0, 1, 1, 0, 1, 0);
        refill(32'h7000_E000, 0, 1, 32'h0, 1, 0, 1, 0);
        lookup("R7 both inst", 32'h7000_E010, 0, 0, 0, 1, 0, 32'h7000_E010);
        lookup("R7 both write", 32'h7000_E010, 0, 1, 1, 1, 0, 32'h7000_E010);
    endtask

    task automatic t_flush_one;
        refill(32'h0800_1000, 0, 1, 32'h0090_0411, 0, 0, 0, 0);
        refill(32'h0800_2000, 0, 1, 32'h00A0_0011, 0, 0, 0, 0);
        flush_one(32'h0800_1000, 0, 0);
        lookup("R9 global spared", 32'h0800_1000, 0, 1, 0, 1, 0, 32'h0090_0000);
        flush_one(32'h0800_1000, 0, 1);
        lookup("R9 global cleared", 32'h0800_1000, 0, 1, 0, 0, 0, 0);
        flush_one(32'h0800_2000, 1, 0);
        lookup("R8 other bank kept", 32'h0800_2000, 0, 1, 0, 1, 0, 32'h00A0_0000);
        flush_one(32'h0800_2000, 0, 0);
        lookup("R8 cleared", 32'h0800_2000, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_big_pages;
        ctl_write(16'hC000);
        chk("R10 ctl 8k", {16'b0, ctl_value}, 32'h0000_C000);
        refill(32'h0900_4000, 0, 1, 32'h00B0_0011, 0, 0, 0, 0);
        refill(32'h0900_5000, 0, 1, 32'h00B0_0011, 0, 0, 0, 0);
        refill(32'h0900_6000, 0, 1, 32'h00C0_0011, 0, 0, 0, 0);
        lookup("R2 8k upper half", 32'h0900_5020, 0, 1, 0, 1, 0, 32'h00B0_1020);
        flush_one(32'h0900_4000, 0, 0);
        lookup("R8 pair index", 32'h0900_4000, 0, 1, 0, 0, 0, 0);
        lookup("R8 pair neighbour", 32'h0900_5000, 0, 1, 0, 0, 0, 0);
        lookup("R8 untouched", 32'h0900_6000, 0, 1, 0, 1, 0, 32'h00C0_0000);
    endtask

    task automatic t_flush_all;
        refill(32'h0A00_7000, 0, 1, 32'h00D0_0411, 0, 0, 0, 0);
        refill(32'h0A00_8000, 0, 1, 32'h00E0_0011, 0, 0, 0, 0);
        flush_all(0);
        lookup("R9 all spares global", 32'h0A00_7000, 0, 1, 0, 1, 0, 32'h00D0_1000);
        lookup("R9 all clears local", 32'h0A00_8000, 0, 1, 0, 0, 0, 0);
        flush_all(1);
        lookup("R9 all global", 32'h0A00_7000, 0, 1, 0, 0, 0, 0);
        refill(32'h0A00_7000, 0, 1, 32'h00D0_0411, 0, 0, 0, 0);
        ctl_write(16'hC000);
        lookup("R10 write clears global", 32'h0A00_7000, 0, 1, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(posedge clk); #1;
        t_reset();
        t_identity();
        t_enable();
        t_normal();
        t_protect();
        t_invalid();
        t_test_status();
        t_transparent();
        t_flush_one();
        t_big_pages();
        t_flush_all();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule